// File: doc/BRIEF.md
# I2C Master Stop and Restart Sequencer

This block handles the bus-condition side of an I2C master. Software writes the upper nibble of a control byte. A write either loads the control fields or starts one of two sequences. The first sequence ends the transfer with a proper stop condition. The second lets go of both lines without a stop, so the bus stays marked busy and a repeated start can follow. The block only drives open-drain pull-low enables for SCL and SDA. It samples both lines every clock, so it can follow start and stop conditions made by any device and can wait while another device stretches the clock.

A stop sequence runs in fixed order. The block holds SDA low and releases SCL. It then waits until SCL is actually seen high, which means no other device is holding it low. After that it releases SDA, and that rising edge is the stop condition. The control fields are frozen from the stop write until the stop has been seen on the bus. After a release, a new start is allowed only when the busy flag reads 0 and the SCL-level bit reads 1. A setup timer reports when the bus has stayed free and idle for a programmable number of clocks. The default of 588 clocks gives 4.7 µs at 125 MHz.

The state machine has five states:
- `ST_IDLE`: nothing is driven.
- `ST_HOLD`: the master owns the bus and pulls both lines low.
- `ST_STOP_SCL`: SDA is held low while the block waits for SCL to read high.
- `ST_STOP_SDA`: both lines are released and the block waits for the stop to be detected.
- `ST_REL_SDA`: SDA is released for one clock while SCL is still held low.

The state machine has these transitions:
- IDLE or HOLD to STOP_SCL on a stop write.
- IDLE or HOLD to REL_SDA on a release write.
- IDLE or HOLD to HOLD or IDLE on a field load.
- STOP_SCL to STOP_SDA once SCL reads high.
- STOP_SDA to IDLE once the stop is detected.
- REL_SDA to IDLE unconditionally.

Top module: `i2cbc_stop_restart`

## Requirements
- R1: `ctl_rdata` presents the four control fields at fixed bit positions: master at bit 7, transmit at bit 6, busy request at bit 5 and pending at bit 4. Bits 3..0 read 0. After reset `ctl_rdata` is 0x00, both line enables are 0 and `stat_busy` is 0.
- R2: `stat_busy` is set after a start condition is sampled on the bus (SDA falls while SCL is high). It is cleared after a stop condition is sampled (SDA rises while SCL is high).
- R3: A write of nibble 4'b1101 while `stat_busy` is 1 starts a stop sequence. The block holds SDA low, releases SCL, and keeps SDA low for as long as SCL is held low by another device.
- R4: Once SCL is seen high, the block releases SDA. When the resulting stop is sampled, `stat_busy` clears and the fields become 0x1, so `ctl_rdata` reads 0x10.
- R5: From a stop write until the stop is sampled, further control writes are ignored and `ctl_rdata` stays 0xD0.
- R6: A write of nibble 4'b0001 while the master field is 1 releases the bus. In the next cycle SDA is released while SCL is still held low. In the cycle after that, SCL is released too. No stop is produced, `stat_busy` stays 1 and `ctl_rdata` reads 0x10.
- R7: A write with bit 7 equal to 0 while the master field is 0 is ignored. The fields and the line enables do not change.
- R8: Any other write loads the nibble into the fields. The block then pulls both lines low if and only if the new master bit is 1 and the new pending bit is 0. Otherwise it drives neither line.
- R9: `stat_scl_hi` reads 1 when SCL was sampled high and 0 when it was sampled low, one to two clocks after the line changes.
- R10: `stat_setup_ok` rises after SETUP_CYC consecutive clocks with `stat_busy`=0 and both lines high. It falls within two clocks when any of those conditions stops holding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe, one clock per write |
| ctl_wdata | input | 8 | Control byte; bits 7..4 are used |
| ctl_rdata | output | 8 | Current control fields, low nibble 0 |
| stat_busy | output | 1 | Bus busy flag from detected start and stop conditions |
| stat_scl_hi | output | 1 | Sampled SCL level; 1 means no device pulls SCL low |
| stat_setup_ok | output | 1 | Repeated-start setup interval has elapsed |
| scl_in | input | 1 | Level on the SCL line |
| sda_in | input | 1 | Level on the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume the line inputs are the wired-AND of this block's enables and the other devices' pulls, and that they change only between clock edges. The bench models each line as exactly that AND. Its own pull-downs change only at falling clock edges and hold each level for several clocks. The assertions also assume the other devices make no conditions of their own while a stop sequence is running. The bench therefore changes only SCL during a stop, and only by holding it low.

// File: rtl/i2cbc_pkg.sv
package i2cbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_HOLD     = 3'd1,
        ST_STOP_SCL = 3'd2,
        ST_STOP_SDA = 3'd3,
        ST_REL_SDA  = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic master;
        logic xmit;
        logic busy_req;
        logic pend;
    } ctl_fields_t;

    localparam logic [3:0] NIB_STOP    = 4'b1101;
    localparam logic [3:0] NIB_RELEASE = 4'b0001;
    localparam logic [3:0] NIB_AFTER   = 4'b0001;
    localparam int unsigned FIELD_LSB  = 4;

endpackage

// File: rtl/i2cbc_line_mon.sv
module i2cbc_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_q,
    output logic sda_q,
    output logic bus_busy,
    output logic stop_det
);
    logic scl_p, sda_p;
    logic start_det;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            scl_p <= scl_q;
            sda_p <= sda_q;
        end
    end

    // Conditions: SDA edge while SCL stays high across both samples
    assign start_det = scl_q && scl_p && sda_p && !sda_q;
    assign stop_det  = scl_q && scl_p && !sda_p && sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bus_busy <= 1'b0;
        else if (start_det) bus_busy <= 1'b1;
        else if (stop_det)  bus_busy <= 1'b0;
    end

    assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> bus_busy);
    assert_stop_clears_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !bus_busy);

endmodule

// File: rtl/i2cbc_setup_tmr.sv
module i2cbc_setup_tmr #(
    parameter int unsigned SETUP_CYC = 588
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_busy,
    input  logic scl_q,
    input  logic sda_q,
    output logic setup_ok
);
    localparam int unsigned CW = $clog2(SETUP_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETUP_CYC);

    logic [CW-1:0] cnt_q;
    logic          free_now;

    assign free_now = !bus_busy && scl_q && sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (!free_now)     cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign setup_ok = (cnt_q == LIMIT);

    assert_setup_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !free_now |=> !setup_ok);
    assert_setup_rise_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(setup_ok) |-> $past(free_now));

endmodule

// File: rtl/i2cbc_seq_fsm.sv
module i2cbc_seq_fsm
    import i2cbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [3:0]  wnib,
    input  logic        bus_busy,
    input  logic        scl_q,
    input  logic        stop_det,
    output ctl_fields_t fields_q,
    output logic        scl_oe,
    output logic        sda_oe
);
    seq_state_t state_q, state_d;
    ctl_fields_t fields_d;
    logic accept, do_stop, do_rel, do_ignore, do_load;

    assign accept    = wr && (state_q == ST_IDLE || state_q == ST_HOLD);
    assign do_stop   = accept && (wnib == NIB_STOP) && bus_busy;
    assign do_rel    = accept && (wnib == NIB_RELEASE) && fields_q.master;
    assign do_ignore = accept && !wnib[3] && !fields_q.master;
    assign do_load   = accept && !do_stop && !do_rel && !do_ignore;

    // Next-state and field update
    always_comb begin
        state_d  = state_q;
        fields_d = fields_q;
        unique case (state_q)
            ST_IDLE, ST_HOLD: begin
                if (do_stop) begin
                    state_d  = ST_STOP_SCL;
                    fields_d = ctl_fields_t'(wnib);
                end else if (do_rel) begin
                    state_d  = ST_REL_SDA;
                    fields_d = ctl_fields_t'(wnib);
                end else if (do_load) begin
                    state_d  = (wnib[3] && !wnib[0]) ? ST_HOLD : ST_IDLE;
                    fields_d = ctl_fields_t'(wnib);
                end
            end
            ST_STOP_SCL: begin
                if (scl_q) state_d = ST_STOP_SDA;
            end
            ST_STOP_SDA: begin
                if (stop_det) begin
                    state_d  = ST_IDLE;
                    fields_d = ctl_fields_t'(NIB_AFTER);
                end
            end
            ST_REL_SDA: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            fields_q <= '0;
        end else begin
            state_q  <= state_d;
            fields_q <= fields_d;
        end
    end

    // Outputs: open-drain pull-low enables
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_HOLD:     begin scl_oe = 1'b1; sda_oe = 1'b1; end
            ST_STOP_SCL: sda_oe = 1'b1;
            ST_STOP_SDA: ;
            ST_REL_SDA:  scl_oe = 1'b1;
            default:     ;
        endcase
    end

    assert_stop_waits_scl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP_SCL && !scl_q) |=> (state_q == ST_STOP_SCL));
    assert_stop_done_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP_SDA && stop_det) |=> (state_q == ST_IDLE && fields_q == ctl_fields_t'(NIB_AFTER)));
    assert_fields_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_STOP_SCL || state_q == ST_STOP_SDA) && !stop_det) |=> $stable(fields_q));
    assert_release_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REL_SDA) |=> (state_q == ST_IDLE));
    assert_ignore_mst0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wnib[3] && !fields_q.master && (state_q == ST_IDLE || state_q == ST_HOLD))
        |=> ($stable(fields_q) && $stable(state_q)));

endmodule

// File: rtl/i2cbc_stop_restart.sv
module i2cbc_stop_restart
    import i2cbc_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 588
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    output logic       stat_busy,
    output logic       stat_scl_hi,
    output logic       stat_setup_ok,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    logic        scl_q, sda_q, stop_det;
    ctl_fields_t fields;

    i2cbc_line_mon mon_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_q    (scl_q),
        .sda_q    (sda_q),
        .bus_busy (stat_busy),
        .stop_det (stop_det)
    );

    i2cbc_setup_tmr #(.SETUP_CYC(SETUP_CYC)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_busy (stat_busy),
        .scl_q    (scl_q),
        .sda_q    (sda_q),
        .setup_ok (stat_setup_ok)
    );

    i2cbc_seq_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_wr),
        .wnib     (ctl_wdata[FIELD_LSB +: 4]),
        .bus_busy (stat_busy),
        .scl_q    (scl_q),
        .stop_det (stop_det),
        .fields_q (fields),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe)
    );

    assign ctl_rdata   = {fields, 4'b0000};
    assign stat_scl_hi = scl_q;

    assert_rdata_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[3:0] == 4'b0000);

endmodule

// File: tb/i2cbc_stop_restart_tb.sv
`timescale 1ns/1ps
module i2cbc_stop_restart_tb_top;
    localparam int SETUP = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic stat_busy, stat_scl_hi, stat_setup_ok;
    logic scl_oe, sda_oe;
    logic ext_scl_low = 1'b0;
    logic ext_sda_low = 1'b0;
    wire  scl_line = !scl_oe && !ext_scl_low;
    wire  sda_line = !sda_oe && !ext_sda_low;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    i2cbc_stop_restart #(.SETUP_CYC(SETUP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .stat_busy(stat_busy), .stat_scl_hi(stat_scl_hi),
        .stat_setup_ok(stat_setup_ok), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0; ctl_wdata = 8'h00;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ext_scl_low = 0; ext_sda_low = 0;
        tick(2);
        rst_n = 1'b1;
        tick(2);
    endtask

    // start condition from another device, then both lines freed again
    task automatic ext_start();
        ext_sda_low = 1; tick(3);
        ext_scl_low = 1; tick(3);
        ext_sda_low = 0; tick(3);
        ext_scl_low = 0; tick(3);
    endtask

    task automatic ext_stop();
        ext_scl_low = 1; tick(3);
        ext_sda_low = 1; tick(3);
        ext_scl_low = 0; tick(3);
        ext_sda_low = 0; tick(4);
    endtask

    task automatic hold_bus();
        ext_start();
        wr(8'hE0);
        tick(3);
    endtask

    initial begin
        do_reset();
        chk("R1 reset rdata", ctl_rdata, 8'h00);
        chk("R1 reset oe", {scl_oe, sda_oe}, 0);
        chk("R1 reset busy", stat_busy, 0);

        // R2 busy tracking from external conditions
        ext_start();
        chk("R2 busy after start", stat_busy, 1);
        ext_stop();
        chk("R2 busy cleared by stop", stat_busy, 0);

        // R9 scl level
        ext_scl_low = 1; tick(2);
        chk("R9 scl low", stat_scl_hi, 0);
        ext_scl_low = 0; tick(2);
        chk("R9 scl high", stat_scl_hi, 1);

        // Sweep all nibbles from the held state and from idle-busy
        for (int mode = 0; mode < 2; mode++) begin
            for (int n = 0; n < 16; n++) begin
                logic m_now, is_stop, is_rel, ign;
                int exp_f, exp_oe, exp_busy;
                do_reset();
                if (mode == 0) hold_bus(); else ext_start();
                m_now   = (mode == 0);
                is_stop = (n == 13);
                is_rel  = (n == 1) && m_now;
                ign     = !n[3] && !m_now;
                wr(8'(n << 4));
                tick(12);
                if (is_stop) begin
                    exp_f = 8'h10; exp_oe = 0; exp_busy = 0;
                end else if (is_rel) begin
                    exp_f = 8'h10; exp_oe = 0; exp_busy = 1;
                end else if (ign) begin
                    exp_f = 8'h00; exp_oe = 0; exp_busy = 1;
                end else begin
                    exp_f = n << 4;
                    exp_oe = (n[3] && !n[0]) ? 3 : 0;
                    exp_busy = 1;
                end
                chk(is_stop ? "R4 sweep fields" : is_rel ? "R6 sweep fields" : ign ? "R7 sweep fields" : "R8 sweep fields",
                    ctl_rdata, exp_f);
                chk(ign ? "R7 sweep oe" : "R8 sweep oe", {scl_oe, sda_oe}, exp_oe);
                chk(is_stop ? "R4 sweep busy" : "R6 sweep busy", stat_busy, exp_busy);
            end
        end

        // R3/R5 clock stretched by another device during stop
        do_reset();
        hold_bus();
        ext_scl_low = 1;
        wr(8'hD0);
        tick(20);
        chk("R3 sda held while scl low", sda_oe, 1);
        chk("R3 sda line low", sda_line, 0);
        chk("R3 busy held", stat_busy, 1);
        wr(8'h80);
        wr(8'h00);
        tick(2);
        chk("R5 fields frozen", ctl_rdata, 8'hD0);
        ext_scl_low = 0;
        tick(8);
        chk("R4 sda released", sda_oe, 0);
        chk("R4 busy cleared", stat_busy, 0);
        chk("R4 fields after stop", ctl_rdata, 8'h10);

        // R6 release ordering, then restart readiness and R10 timer
        do_reset();
        hold_bus();
        wr(8'h10);
        chk("R6 sda first", {scl_oe, sda_oe}, 2);
        tick(1);
        chk("R6 scl then", {scl_oe, sda_oe}, 0);
        tick(20);
        chk("R6 busy stays", stat_busy, 1);
        chk("R6 scl free", stat_scl_hi, 1);
        chk("R10 not ok while busy", stat_setup_ok, 0);
        ext_stop();
        begin
            int k = 0;
            while (!stat_busy && !stat_setup_ok && k < 200) begin tick(1); k++; end
            // k counts from the first low-busy sample, so add ext_stop tail (4 clocks)
            checks++;
            if ((k + 4) < SETUP - 1 || (k + 4) > SETUP + 2) begin
                errors++;
                $display("FAIL R10 setup delay actual=%0d expected=%0d", k + 4, SETUP);
            end
        end
        chk("R10 ok", stat_setup_ok, 1);
        ext_sda_low = 1; tick(2);
        chk("R10 drops", stat_setup_ok, 0);
        ext_sda_low = 0; tick(2);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule